// File: doc/BRIEF.md
# Adaptive Bank-to-Cluster Distribution Network

This block sits between four stream register file banks and four compute clusters. Each bank pushes words into a small private queue. A set of output registers hands those words to the clusters. The network supports four operating modes, so the number of clusters that do work can follow the data parallelism of the current workload.

- **Full mode:** every bank feeds the cluster with the same index.
- **Half mode:** two clusters each take two banks in fixed alternating time slots.
- **Quarter mode:** one cluster visits all four banks in turn.
- **Off mode:** nothing is delivered and every cluster is told to power down.

The point of the block is that data stranded in a bank whose own cluster is switched off still reaches an active cluster. It does not have to be written back to memory and reloaded first.

A requested mode is adopted only once every bank queue has drained. While a request is pending, the banks are refused, which guarantees that draining happens. The per-cluster power enables change on the same clock edge as the mode. A newly enabled cluster is therefore powered for at least one cycle before its first word arrives. Each delivered word carries the number of the bank it came from.

Top module: `srf_cluster_mux`

## Requirements
- R1: After reset the active mode is full (code 0), all four power enables are high, no cluster valid is asserted, and every bank is ready while the requested mode is 0.
- R2: In full mode (code 0), cluster c delivers the words of bank c in arrival order. A word accepted at clock edge k appears at edge k+1 at the earliest.
- R3: In half mode (code 1), a slot counter restarts at 0 on the edge that adopts the mode and advances every cycle. Cluster c (c = 0 or 1) drains bank c when the slot is even and bank c+2 when the slot is odd, one word per cycle at most. Clusters 2 and 3 never assert valid.
- R4: In quarter mode (code 2), cluster 0 drains bank number (slot mod 4), at most one word per cycle. Clusters 1 to 3 never assert valid.
- R5: In off mode (code 3), no cluster valid is asserted and all bank ready signals are low.
- R6: The power enable vector (bit c for cluster c) is 4'b1111 in full, 4'b0011 in half, 4'b0001 in quarter and 4'b0000 in off mode. It changes on the same edge as the active mode.
- R7: A requested mode that differs from the active mode is adopted only on an edge where all four queues were empty. While the request differs, all bank ready signals are low. `activeMode` shows the adopted mode.
- R8: A bank's ready is low while its queue (depth `QUEUE_DEPTH`) is full. No accepted word is lost, duplicated or reordered within a bank.
- R9: Each valid output word carries a 2-bit tag equal to the source bank number, in `clusterTag[2c+1:2c]`.
- R10: A cluster asserts valid only while its power enable is high and was already high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeReq | input | 2 | Requested mode: 0 full, 1 half, 2 quarter, 3 off |
| bankData | input | 4*DATA_W | Bank b word at bits [b*DATA_W +: DATA_W] |
| bankValid | input | 4 | Bank b offers a word |
| bankReady | output | 4 | Bank b word is accepted when valid and ready |
| clusterData | output | 4*DATA_W | Cluster c word at bits [c*DATA_W +: DATA_W] |
| clusterTag | output | 8 | Source bank of cluster c word at bits [2c+1:2c] |
| clusterValid | output | 4 | Cluster c receives a word this cycle |
| clusterPowerEn | output | 4 | High keeps cluster c powered |
| activeMode | output | 2 | Currently adopted mode |

## Verification
Every mode is visited several times, and each mode is entered while all banks are still pushing. That stresses the drain-before-switch rule and the refusal of banks during a pending request.

Within each mode, three input patterns are applied:
- **All banks streaming:** fills the queues in the reduced modes and so exposes backpressure and slot fairness.
- **One bank at a time:** shows whether each bank lands on the correct cluster in the correct slot, with the correct tag.
- **Staggered sparse traffic:** catches any scheduler that skips or double-serves a slot when queues are briefly empty.

The mode order (full to half to quarter to off and back, then quarter to half) covers power enables both rising and falling.

// File: rtl/srf_mux_pkg.sv
package srf_mux_pkg;

  localparam int NUM_BANKS = 4;
  localparam int TAG_W     = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_HALF    = 2'd1,
    MODE_QUARTER = 2'd2,
    MODE_OFF     = 2'd3
  } mux_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0]            drainEn;  // cluster may take a word this cycle
    logic [NUM_BANKS-1:0][TAG_W-1:0] srcBank;  // bank each cluster reads
    logic                            acceptEn; // banks may push
  } mux_strobe_t;

  function automatic int activeCount(input mux_mode_e m);
    case (m)
      MODE_FULL:    return NUM_BANKS;
      MODE_HALF:    return NUM_BANKS / 2;
      MODE_QUARTER: return NUM_BANKS / 4;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/srf_bank_queue.sv
module srf_bank_queue #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isFull
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  fill;

  assign isEmpty  = (fill == '0);
  assign isFull   = (fill == CNT_W'(DEPTH));
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (pushEn) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (pushEn) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popEn)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pushEn |-> !isFull);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    popEn |-> !isEmpty);

endmodule

// File: rtl/srf_mux_datapath.sv
module srf_mux_datapath
  import srf_mux_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  mux_strobe_t                   strobe,
  input  logic [NUM_BANKS*DATA_W-1:0]   bankData,
  input  logic [NUM_BANKS-1:0]          bankValid,
  output logic [NUM_BANKS-1:0]          bankReady,
  output logic [NUM_BANKS-1:0]          queueEmpty,
  output logic [NUM_BANKS*DATA_W-1:0]   clusterData,
  output logic [NUM_BANKS*TAG_W-1:0]    clusterTag,
  output logic [NUM_BANKS-1:0]          clusterValid
);

  logic [NUM_BANKS-1:0] queueFull, pushEn, popEn, grant;
  logic [DATA_W-1:0]    headWord [NUM_BANKS];
  logic [NUM_BANKS-1:0] hitMap   [NUM_BANKS]; // hitMap[bank][cluster]

  always_comb begin
    for (int c = 0; c < NUM_BANKS; c++) begin
      grant[c] = strobe.drainEn[c] && !queueEmpty[strobe.srcBank[c]];
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int c = 0; c < NUM_BANKS; c++) begin
        hitMap[b][c] = grant[c] && (strobe.srcBank[c] == TAG_W'(b));
      end
      popEn[b] = |hitMap[b];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankReady[b] = strobe.acceptEn && !queueFull[b];
    assign pushEn[b]    = bankValid[b] && bankReady[b];

    srf_bank_queue #(.DATA_W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .pushEn   (pushEn[b]),
      .pushData (bankData[b*DATA_W +: DATA_W]),
      .popEn    (popEn[b]),
      .headData (headWord[b]),
      .isEmpty  (queueEmpty[b]),
      .isFull   (queueFull[b])
    );

    // a bank is never drained by two clusters in the same cycle
    assert_single_reader_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hitMap[b]));
  end

  for (genvar c = 0; c < NUM_BANKS; c++) begin : g_cluster
    logic              outValid;
    logic [DATA_W-1:0] outData;
    logic [TAG_W-1:0]  outTag;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        outValid <= 1'b0;
        outData  <= '0;
        outTag   <= '0;
      end else begin
        outValid <= grant[c];
        if (grant[c]) begin
          outData <= headWord[strobe.srcBank[c]];
          outTag  <= strobe.srcBank[c];
        end
      end
    end

    assign clusterValid[c]                   = outValid;
    assign clusterData[c*DATA_W +: DATA_W]   = outData;
    assign clusterTag[c*TAG_W +: TAG_W]      = outTag;
  end

endmodule

// File: rtl/srf_mux_control.sv
module srf_mux_control
  import srf_mux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           modeReq,
  input  logic [NUM_BANKS-1:0] queueEmpty,
  output mux_strobe_t          strobe,
  output logic [1:0]           activeMode,
  output logic [NUM_BANKS-1:0] clusterPowerEn
);

  mux_mode_e        curMode, reqMode;
  logic [TAG_W-1:0] slot;
  logic             allEmpty, switchNow;

  assign reqMode    = mux_mode_e'(modeReq);
  assign allEmpty   = &queueEmpty;
  assign switchNow  = (reqMode != curMode) && allEmpty;
  assign activeMode = curMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curMode        <= MODE_FULL;
      slot           <= '0;
      clusterPowerEn <= '1;
    end else if (switchNow) begin
      curMode <= reqMode;
      slot    <= '0;
      for (int c = 0; c < NUM_BANKS; c++) begin
        clusterPowerEn[c] <= (c < activeCount(reqMode));
      end
    end else begin
      slot <= slot + 1'b1;
    end
  end

  always_comb begin
    int act, groups, srcIdx;
    act    = activeCount(curMode);
    groups = (act > 0) ? NUM_BANKS / act : 1;
    strobe.acceptEn = (curMode != MODE_OFF) && (reqMode == curMode);
    for (int c = 0; c < NUM_BANKS; c++) begin
      srcIdx            = c + act * (int'(slot) % groups);
      strobe.drainEn[c] = (c < act);
      strobe.srcBank[c] = TAG_W'(srcIdx);
    end
  end

  assert_switch_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode != $past(curMode)) |-> $past(allEmpty));
  assert_power_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == $past(curMode)) |-> $stable(clusterPowerEn));
  assert_power_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == MODE_OFF) |-> (clusterPowerEn == '0));
  assert_power_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == MODE_FULL) |-> (clusterPowerEn == '1));

endmodule

// File: rtl/srf_cluster_mux.sv
module srf_cluster_mux
  import srf_mux_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  modeReq,
  input  logic [NUM_BANKS*DATA_W-1:0] bankData,
  input  logic [NUM_BANKS-1:0]        bankValid,
  output logic [NUM_BANKS-1:0]        bankReady,
  output logic [NUM_BANKS*DATA_W-1:0] clusterData,
  output logic [NUM_BANKS*TAG_W-1:0]  clusterTag,
  output logic [NUM_BANKS-1:0]        clusterValid,
  output logic [NUM_BANKS-1:0]        clusterPowerEn,
  output logic [1:0]                  activeMode
);

  mux_strobe_t          strobe;
  logic [NUM_BANKS-1:0] queueEmpty;

  srf_mux_control u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .modeReq        (modeReq),
    .queueEmpty     (queueEmpty),
    .strobe         (strobe),
    .activeMode     (activeMode),
    .clusterPowerEn (clusterPowerEn)
  );

  srf_mux_datapath #(.DATA_W(DATA_W), .QUEUE_DEPTH(QUEUE_DEPTH)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .bankData     (bankData),
    .bankValid    (bankValid),
    .bankReady    (bankReady),
    .queueEmpty   (queueEmpty),
    .clusterData  (clusterData),
    .clusterTag   (clusterTag),
    .clusterValid (clusterValid)
  );

  for (genvar c = 0; c < NUM_BANKS; c++) begin : g_pwr_chk
    assert_power_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clusterValid[c] |-> (clusterPowerEn[c] && $past(clusterPowerEn[c])));
  end

  assert_off_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_OFF) |-> (bankReady == '0 && clusterValid == '0));
  assert_pending_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReq != activeMode) |-> (bankReady == '0));
  assert_quarter_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_QUARTER) |-> (clusterValid[NUM_BANKS-1:1] == '0));
  assert_half_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_HALF) |-> (clusterValid[NUM_BANKS-1:NUM_BANKS/2] == '0));

endmodule

// File: tb/sim_srf_cluster_mux.sv
`timescale 1ns/1ps
module sim_srf_cluster_mux;

  localparam int NB = 4;
  localparam int DW = 16;
  localparam int QD = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic            rst_n;
  logic [1:0]      drvMode;
  logic [NB-1:0]   drvValid;
  logic [DW-1:0]   drvData [NB];
  logic [NB*DW-1:0] bankData;
  logic [NB-1:0]   bankReady, clusterValid, clusterPowerEn;
  logic [NB*DW-1:0] clusterData;
  logic [NB*2-1:0] clusterTag;
  logic [1:0]      activeMode;

  always_comb begin
    for (int b = 0; b < NB; b++) bankData[b*DW +: DW] = drvData[b];
  end

  srf_cluster_mux #(.DATA_W(DW), .QUEUE_DEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .modeReq(drvMode), .bankData(bankData),
    .bankValid(drvValid), .bankReady(bankReady), .clusterData(clusterData),
    .clusterTag(clusterTag), .clusterValid(clusterValid),
    .clusterPowerEn(clusterPowerEn), .activeMode(activeMode)
  );

  int checks = 0;
  int errors = 0;
  int seq = 0;

  // reference model state
  int            mMode, mSlot;
  int            mCnt [NB];
  int            mHead[NB];
  logic [DW-1:0] mBuf [NB][QD];
  logic [NB-1:0] eValid, ePow, prevPow;
  logic [DW-1:0] eData[NB];
  int            eTag [NB];

  function automatic int actOf(input int m);
    case (m)
      0: return 4;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string modeReqName(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic setDrive(input logic [NB-1:0] v);
    drvValid = v;
    for (int b = 0; b < NB; b++) begin
      drvData[b] = {b[1:0], seq[13:0]};
      seq++;
    end
  endtask

  // one clock cycle: check ready, advance model, check registered outputs
  task automatic tick();
    int act, groups, src, oldMode;
    bit pend, allEmpty;
    logic [NB-1:0] rdy;
    #1;
    prevPow  = clusterPowerEn;
    oldMode  = mMode;
    act      = actOf(mMode);
    pend     = (int'(drvMode) != mMode);
    allEmpty = 1'b1;
    for (int b = 0; b < NB; b++) if (mCnt[b] != 0) allEmpty = 1'b0;
    for (int b = 0; b < NB; b++) rdy[b] = (mMode != 3) && !pend && (mCnt[b] < QD);
    check(bankReady === rdy, pend ? "R7" : (mMode == 3 ? "R5" : "R8"),
          "bankReady", int'(bankReady), int'(rdy));
    for (int c = 0; c < NB; c++) begin
      eValid[c] = 1'b0;
      if (c < act) begin
        groups = NB / act;
        src    = c + act * (mSlot % groups);
        if (mCnt[src] > 0) begin
          eValid[c]  = 1'b1;
          eData[c]   = mBuf[src][mHead[src]];
          eTag[c]    = src;
          mHead[src] = (mHead[src] + 1) % QD;
          mCnt[src]--;
        end
      end
    end
    for (int b = 0; b < NB; b++) begin
      if (drvValid[b] && rdy[b]) begin
        mBuf[b][(mHead[b] + mCnt[b]) % QD] = drvData[b];
        mCnt[b]++;
      end
    end
    if (pend && allEmpty) begin
      mMode = int'(drvMode);
      mSlot = 0;
    end else begin
      mSlot = (mSlot + 1) % 4;
    end
    for (int c = 0; c < NB; c++) ePow[c] = (c < actOf(mMode));
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NB; c++) begin
      check(clusterValid[c] === eValid[c], modeReqName(oldMode), "clusterValid",
            int'(clusterValid[c]), int'(eValid[c]));
      if (eValid[c]) begin
        check(clusterData[c*DW +: DW] === eData[c], modeReqName(oldMode), "clusterData",
              int'(clusterData[c*DW +: DW]), int'(eData[c]));
        check(int'(clusterTag[c*2 +: 2]) == eTag[c], "R9", "clusterTag",
              int'(clusterTag[c*2 +: 2]), eTag[c]);
      end
      if (clusterValid[c])
        check(prevPow[c] === 1'b1, "R10", "power before data", int'(prevPow[c]), 1);
    end
    check(clusterPowerEn === ePow, "R6", "clusterPowerEn", int'(clusterPowerEn), int'(ePow));
    check(int'(activeMode) == mMode, "R7", "activeMode", int'(activeMode), mMode);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int modeList[7] = '{1, 2, 3, 0, 2, 1, 0};
    int n;
    rst_n   = 1'b0;
    drvMode = 2'd0;
    drvValid = '0;
    for (int b = 0; b < NB; b++) begin
      drvData[b] = '0;
      mCnt[b] = 0;
      mHead[b] = 0;
    end
    mMode = 0;
    mSlot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(clusterValid === 4'b0000, "R1", "reset valid", int'(clusterValid), 0);
    check(clusterPowerEn === 4'b1111, "R1", "reset power", int'(clusterPowerEn), 15);
    check(activeMode === 2'd0, "R1", "reset mode", int'(activeMode), 0);
    check(bankReady === 4'b1111, "R1", "reset ready", int'(bankReady), 15);
    @(negedge clk);

    // full mode traffic first, then each listed mode entered under load
    repeat (10) begin setDrive('1); tick(); end
    foreach (modeList[i]) begin
      drvMode = 2'(modeList[i]);
      n = 0;
      while (mMode != modeList[i] && n < 80) begin
        setDrive('1); tick(); n++;
      end
      repeat (2) begin setDrive('1); tick(); end
      repeat (12) begin setDrive('1); tick(); end          // all streaming
      repeat (20) begin setDrive('0); tick(); end          // drain
      for (int b = 0; b < NB; b++) begin                   // one bank at a time
        repeat (3) begin setDrive(4'(1 << b)); tick(); end
        repeat (8) begin setDrive('0); tick(); end
      end
      for (int k = 0; k < 16; k++) begin                   // staggered sparse
        logic [NB-1:0] v;
        for (int b = 0; b < NB; b++) v[b] = ((k + b) % 3 == 0);
        setDrive(v); tick();
      end
    end
    repeat (20) begin setDrive('0); tick(); end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule